// File: doc/BRIEF.md
# Disk Controller Reset Arbiter

This block decides when a disk-controller core is held in reset and when it leaves reset. Four things can put the core into reset. The first two are a power-on reset and an external hardware reset pin, which are merged into one input stage that asserts at once and releases on the clock. The other two are software resets set through host register writes. One is a sticky bit in the output-control register, and the other is a self-clearing bit in the rate-select register. The pin stage also forces the sticky bit on, so after a pin reset the core stays in reset until the host writes that bit back to its inactive value.

From these sources the block drives several outputs:
- a core reset level, and a wake request that keeps the core out of power-down;
- a one-cycle abort strobe when a reset begins, so any write in progress is cut short;
- a clear level for the full register set, which only the pin or power-on source raises (the drive timing values are not in its scope);
- a clear level for drive status and FIFO state, which every source raises;
- a source code that names the reset currently in force.

When the last source goes away, the block gives a one-cycle exit pulse. The same pulse clears the stored configuration. Drive polling is then enabled, with a start strobe one cycle later. A later configuration write can turn polling off, or turn it back on.

Top module: `dskc_rst_seq`

## Requirements
- R1: A low level on `por_n` or `pin_rst_n` asserts `core_rst`, `full_clr` and `wake` with no clock edge. `full_clr` is deasserted on the second rising clock edge after both inputs are high.
- R2: While the pin stage is active, `ctl_rst_bit` reads 1. It stays 1 after release until a host write to the output-control register (`wr_sel`=0) with data bit 2 = 1. A write with data bit 2 = 0 sets it to 1. The other data bits have no effect.
- R3: A write to the rate-select register (`wr_sel`=1) with data bit 7 = 1 raises `rate_rst_bit` for exactly 4 cycles, after which it returns to 0 with no further write. Data bit 7 = 0 has no effect.
- R4: While `ctl_rst_bit` is 1, a rate-select reset write is ignored, so `rate_rst_bit` stays 0.
- R5: `core_rst` is the OR of the three sources. `src_code` reports the one in force by priority: 3 = pin/power-on, 2 = output-control bit, 1 = rate-select bit, 0 = none.
- R6: `full_clr` is high only for the pin/power-on source. `soft_clr` is high whenever `core_rst` is high, for any source.
- R7: `wake` follows `core_rst`. `abort_op` pulses for one cycle on the first cycle of a software reset, and stays high throughout a pin/power-on reset.
- R8: `exit_pulse` and `cfg_clr` are high for exactly the one cycle in which `core_rst` is first low after being high.
- R9: `poll_en` becomes 1 on the edge that ends the exit cycle, and `poll_start` is high for that next cycle. A `cfg_wr` outside reset sets `poll_en` to the inverse of `cfg_poll_off`. While in reset `poll_en` is 0 and `cfg_wr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | Write target: 0 output-control, 1 rate-select |
| wr_data | input | 8 | Host write data |
| cfg_wr | input | 1 | Configuration command write strobe |
| cfg_poll_off | input | 1 | With cfg_wr: 1 disables polling, 0 enables it |
| core_rst | output | 1 | Core held in reset |
| full_clr | output | 1 | Clear all registers except drive timing values |
| soft_clr | output | 1 | Clear drive status and FIFO |
| abort_op | output | 1 | Terminate operation in progress |
| wake | output | 1 | Power-down exit request |
| exit_pulse | output | 1 | One cycle at reset exit |
| cfg_clr | output | 1 | Clear stored configuration |
| poll_en | output | 1 | Drive polling enabled |
| poll_start | output | 1 | One-cycle polling start strobe |
| src_code | output | 2 | Active reset source code |
| ctl_rst_bit | output | 1 | Sticky software reset state |
| rate_rst_bit | output | 1 | Self-clearing software reset state |

## Verification
Several properties are checked on every cycle: the exit and abort strobes last a single cycle, the sticky bit holds until a write to it, the self-clearing counter stays within its length and drops the bit when it runs out, a blocked rate write leaves the bit low, and polling follows every exit. Other behaviour can only be shown by the bench scenarios. These cover the exact four-cycle length of the rate reset, the register-clear scope of each source, and the asynchronous assertion between clock edges. They also cover the full sweep of write data through both registers, with the resulting source code and the exit timing.

// File: rtl/dskc_rst_pkg.sv
package dskc_rst_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_RATE   = 2'd1,
    SRC_CTL    = 2'd2,
    SRC_HARD   = 2'd3
  } rst_src_e;

  // priority encoder of active reset sources
  function automatic rst_src_e pick_src(input logic hard, input logic ctl, input logic rate);
    if (hard)      return SRC_HARD;
    else if (ctl)  return SRC_CTL;
    else if (rate) return SRC_RATE;
    else           return SRC_NONE;
  endfunction

  // counter width that can hold the value n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/dskc_rst_sync.sv
module dskc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_rst_n,
  output logic hard_rst
);
  logic any_n;
  logic [STAGES-1:0] chain;

  assign any_n = por_n & pin_rst_n;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge any_n) begin
          if (!any_n) chain[i] <= 1'b0;
          else        chain[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge any_n) begin
          if (!any_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign hard_rst = ~chain[STAGES-1];

endmodule

// File: rtl/dskc_sticky_rst.sv
module dskc_sticky_rst #(
  parameter int DW  = 8,
  parameter int POS = 2
) (
  input  logic          clk,
  input  logic          hard_rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  output logic          sticky
);
  logic wr_bit;
  assign wr_bit = wr_data[POS];

  // bit is stored as "reset active"; host bit value 0 means reset requested
  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)    sticky <= 1'b1;
    else if (wr_hit) sticky <= ~wr_bit;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (hard_rst)
    (sticky && !wr_hit) |=> sticky); // R2
  AST_STICKY_WRITE: assert property (@(posedge clk) disable iff (hard_rst)
    wr_hit |=> (sticky == !$past(wr_bit))); // R2

endmodule

// File: rtl/dskc_selfclr_rst.sv
module dskc_selfclr_rst
  import dskc_rst_pkg::*;
#(
  parameter int DW  = 8,
  parameter int POS = 7,
  parameter int LEN = 4
) (
  input  logic          clk,
  input  logic          hard_rst,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          block,
  output logic          active
);
  localparam int CW = cnt_bits(LEN);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] cnt;
  logic          load;

  assign load   = wr_hit & wr_data[POS] & ~block;
  assign active = (cnt != '0);

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)         cnt <= '0;
    else if (load)        cnt <= LEN_V;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  always_comb begin
    AST_CNT_RANGE: assert (cnt <= LEN_V); // R3
  end

  AST_SELF_DROP: assert property (@(posedge clk) disable iff (hard_rst)
    (cnt == CW'(1) && !load) |=> !active); // R3
  AST_BLOCKED: assert property (@(posedge clk) disable iff (hard_rst)
    (!active && block && wr_hit) |=> !active); // R4

endmodule

// File: rtl/dskc_rst_seq.sv
module dskc_rst_seq
  import dskc_rst_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SYNC_STG  = 2,
  parameter int CTL_POS   = 2,
  parameter int RATE_POS  = 7,
  parameter int RATE_LEN  = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          pin_rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_wr,
  input  logic          cfg_poll_off,
  output logic          core_rst,
  output logic          full_clr,
  output logic          soft_clr,
  output logic          abort_op,
  output logic          wake,
  output logic          exit_pulse,
  output logic          cfg_clr,
  output logic          poll_en,
  output logic          poll_start,
  output logic [1:0]    src_code,
  output logic          ctl_rst_bit,
  output logic          rate_rst_bit
);
  logic     hard_rst;
  logic     ctl_hit, rate_hit;
  logic     rst_q, poll_q;
  logic     onset;
  rst_src_e src;

  assign ctl_hit  = wr_en & ~wr_sel;
  assign rate_hit = wr_en &  wr_sel;

  dskc_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk       (clk),
    .por_n     (por_n),
    .pin_rst_n (pin_rst_n),
    .hard_rst  (hard_rst)
  );

  dskc_sticky_rst #(.DW(DW), .POS(CTL_POS)) u_ctl (
    .clk      (clk),
    .hard_rst (hard_rst),
    .wr_hit   (ctl_hit),
    .wr_data  (wr_data),
    .sticky   (ctl_rst_bit)
  );

  dskc_selfclr_rst #(.DW(DW), .POS(RATE_POS), .LEN(RATE_LEN)) u_rate (
    .clk      (clk),
    .hard_rst (hard_rst),
    .wr_hit   (rate_hit),
    .wr_data  (wr_data),
    .block    (ctl_rst_bit),
    .active   (rate_rst_bit)
  );

  // named internal events
  assign src        = pick_src(hard_rst, ctl_rst_bit, rate_rst_bit);
  assign core_rst   = (src != SRC_NONE);
  assign onset      = core_rst & ~rst_q;
  assign exit_pulse = ~core_rst & rst_q;

  assign src_code   = src;
  assign full_clr   = hard_rst;
  assign soft_clr   = core_rst;
  assign wake       = core_rst;
  assign abort_op   = hard_rst | onset;
  assign cfg_clr    = exit_pulse;
  assign poll_start = poll_en & ~poll_q;

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst) begin
      rst_q  <= 1'b1;
      poll_q <= 1'b0;
    end else begin
      rst_q  <= core_rst;
      poll_q <= poll_en;
    end
  end

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)        poll_en <= 1'b0;
    else if (core_rst)   poll_en <= 1'b0;
    else if (exit_pulse) poll_en <= 1'b1;
    else if (cfg_wr)     poll_en <= ~cfg_poll_off;
  end

  always_comb begin
    if (ctl_rst_bit) begin
      AST_SRC_PRI: assert (src_code >= 2'd2); // R5
    end
  end

  AST_EXIT_ONE: assert property (@(posedge clk) disable iff (hard_rst)
    exit_pulse |=> !exit_pulse); // R8
  AST_ABORT_ONE: assert property (@(posedge clk) disable iff (hard_rst)
    onset |=> !onset); // R7
  AST_POLL_AFTER_EXIT: assert property (@(posedge clk) disable iff (hard_rst)
    exit_pulse |=> (poll_en && poll_start)); // R9
  AST_NO_POLL_IN_RST: assert property (@(posedge clk) disable iff (hard_rst)
    core_rst |=> !poll_start); // R9

endmodule

// File: tb/sim_dskc_rst_seq.sv
module sim_dskc_rst_seq;
  logic       clk = 1'b0;
  logic       por_n, pin_rst_n, wr_en, wr_sel, cfg_wr, cfg_poll_off;
  logic [7:0] wr_data;
  logic       core_rst, full_clr, soft_clr, abort_op, wake, exit_pulse, cfg_clr;
  logic       poll_en, poll_start, ctl_rst_bit, rate_rst_bit;
  logic [1:0] src_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dskc_rst_seq u0 (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_wr(cfg_wr), .cfg_poll_off(cfg_poll_off),
    .core_rst(core_rst), .full_clr(full_clr), .soft_clr(soft_clr), .abort_op(abort_op),
    .wake(wake), .exit_pulse(exit_pulse), .cfg_clr(cfg_clr), .poll_en(poll_en),
    .poll_start(poll_start), .src_code(src_code), .ctl_rst_bit(ctl_rst_bit),
    .rate_rst_bit(rate_rst_bit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // advance one clock; return at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic cfg(input logic off);
    cfg_wr = 1'b1; cfg_poll_off = off;
    step();
    cfg_wr = 1'b0;
  endtask

  // expected reset summary from source levels
  function automatic int exp_src(input bit h, input bit c, input bit r);
    return h ? 3 : (c ? 2 : (r ? 1 : 0));
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit prev_rst;
    por_n = 1'b0; pin_rst_n = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    cfg_wr = 1'b0; cfg_poll_off = 1'b0;
    repeat (3) step();

    // reset state under power-on
    chk("R1 core_rst at por", core_rst, 1);
    chk("R1 full_clr at por", full_clr, 1);
    chk("R1 wake at por", wake, 1);
    chk("R5 src at por", src_code, 3);
    chk("R2 ctl bit at por", ctl_rst_bit, 1);
    chk("R9 poll_en at por", poll_en, 0);
    chk("R7 abort at por", abort_op, 1);

    por_n = 1'b1;
    step();
    chk("R1 still hard after 1 edge", full_clr, 1);
    step();
    chk("R1 hard released after 2 edges", full_clr, 0);
    chk("R2 ctl bit stays after release", ctl_rst_bit, 1);
    chk("R5 src ctl", src_code, 2);
    chk("R6 soft_clr ctl", soft_clr, 1);
    chk("R9 cfg ignored setup", poll_en, 0);
    cfg(1'b0);
    chk("R9 cfg ignored in reset", poll_en, 0);

    reg_wr(1'b0, 8'h04);
    chk("R2 ctl bit cleared", ctl_rst_bit, 0);
    chk("R5 core released", core_rst, 0);
    chk("R8 exit pulse", exit_pulse, 1);
    chk("R8 cfg_clr", cfg_clr, 1);
    chk("R9 poll not yet", poll_en, 0);
    step();
    chk("R8 exit one cycle", exit_pulse, 0);
    chk("R9 poll_en after exit", poll_en, 1);
    chk("R9 poll_start", poll_start, 1);
    step();
    chk("R9 poll_start one cycle", poll_start, 0);
    cfg(1'b1);
    chk("R9 cfg poll off", poll_en, 0);
    cfg(1'b0);
    chk("R9 cfg poll on", poll_en, 1);

    // sweep every value through the output-control register
    prev_rst = 1'b0;
    for (int v = 0; v < 256; v++) begin
      bit now_rst;
      now_rst = ~v[2];
      reg_wr(1'b0, 8'(v));
      chk("R2 ctl bit sweep", ctl_rst_bit, int'(now_rst));
      chk("R5 src sweep", src_code, exp_src(0, now_rst, 0));
      chk("R7 abort onset sweep", abort_op, int'(now_rst & ~prev_rst));
      chk("R8 exit sweep", exit_pulse, int'(prev_rst & ~now_rst));
      chk("R6 full_clr soft", full_clr, 0);
      prev_rst = now_rst;
    end

    // sweep every value through the rate-select register
    for (int v = 0; v < 256; v++) begin
      reg_wr(1'b1, 8'(v));
      if (v[7]) begin
        chk("R3 rate bit set", rate_rst_bit, 1);
        chk("R5 src rate", src_code, 1);
        chk("R7 abort onset rate", abort_op, 1);
        chk("R6 soft_clr rate", soft_clr, 1);
        for (int k = 0; k < 3; k++) begin
          step();
          chk("R3 rate bit held", rate_rst_bit, 1);
        end
        step();
        chk("R3 rate bit self-cleared", rate_rst_bit, 0);
        chk("R8 exit after rate", exit_pulse, 1);
      end else begin
        chk("R3 rate bit7 zero ignored", rate_rst_bit, 0);
        chk("R5 no reset", core_rst, 0);
      end
      step();
    end

    // precedence of the sticky bit
    reg_wr(1'b0, 8'h00);
    reg_wr(1'b1, 8'h80);
    chk("R4 rate write ignored", rate_rst_bit, 0);
    chk("R4 src ctl", src_code, 2);
    reg_wr(1'b0, 8'h04);
    chk("R4 no lingering rate reset", core_rst, 0);
    step();

    // pin reset mid-cycle while a rate reset runs
    reg_wr(1'b1, 8'h80);
    #3 pin_rst_n = 1'b0;
    #2;
    chk("R1 async assert", core_rst, 1);
    chk("R5 src hard", src_code, 3);
    chk("R6 full_clr pin", full_clr, 1);
    chk("R7 wake pin", wake, 1);
    @(negedge clk);
    chk("R2 ctl forced by pin", ctl_rst_bit, 1);
    chk("R1 rate cleared by pin", rate_rst_bit, 0);
    pin_rst_n = 1'b1;
    step(); step();
    chk("R6 full_clr off ctl remains", full_clr, 0);
    chk("R2 ctl after pin", ctl_rst_bit, 1);
    chk("R7 abort off in ctl hold", abort_op, 0);
    reg_wr(1'b0, 8'hFB);
    chk("R2 bit2 zero keeps reset", ctl_rst_bit, 1);
    reg_wr(1'b0, 8'h04);
    chk("R8 exit after pin", exit_pulse, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule